// File: doc/BRIEF.md
# Processor status flag register

This block keeps the six architectural condition and control flags of an 8-bit accumulator CPU: negative (N), overflow (V), decimal (D), interrupt mask (I), zero (Z) and carry (C). Each cycle the decoder presents a 4-bit instruction class code together with the flag results from the ALU. The block applies only the updates that this class is allowed to make, so each flag has its own set of sources. It also takes a pull-from-stack restore and an interrupt-entry strobe. It presents the flags to branch logic, gates the maskable interrupt request, and forms the byte that a push writes to the stack.

The status byte runs from bit 7 down to bit 0 as N, V, 1, B, D, I, Z, C. Bit 5 is a constant 1. Bit 4 is a break marker that exists only in the pushed copy. It reads 1 on an ordinary push. During interrupt entry it shows whether the entry came from a software break (1) or a hardware request (0). Branch logic reads `status`, which shows 1 in both of those positions.

Top module: `status_flags`

## Requirements
- R1: While `rst_n` is low, and after it is released with no other activity, `status` is 8'h34: N=V=D=Z=C=0 and I=1.
- R2: `push_byte` is {N,V,1,1,D,I,Z,C} whenever `int_entry` is 0, and bit 5 of both `status` and `push_byte` is always 1.
- R3: While `int_entry` is 1, bit 4 of `push_byte` equals `int_is_brk` and the other bits follow R2. The break value is never stored, so `status[4]` stays 1.
- R4: With `restore_en` high, the next `status` takes bits 7,6,3,2,1,0 from `restore_byte`. Bits 5 and 4 of `restore_byte` have no effect.
- R5: On `int_entry` (without restore), D is cleared and I is set at the next edge. N, V, Z and C are left to the class code of that cycle.
- R6: V is written only by class 2 (add/subtract, V=`alu_v`), class 4 (memory bit test, V=`alu_v`), class 8 (clear V) and a restore. Class 3 (shift/compare) leaves V unchanged.
- R7: C is written only by class 2 and class 3 (C=`alu_c`), class 6 (clear C), class 7 (set C) and a restore. Class 1 (load/transfer/logic/increment/decrement) leaves C unchanged.
- R8: N and Z take `alu_n` and `alu_z` on classes 1, 2, 3 and 4. Class 0 (store, transfer to stack pointer, no flag effect) and the unused codes 13 to 15 change no flag.
- R9: Class 5 (bit test-and-set/reset, immediate bit test) writes only Z from `alu_z` and leaves N and V unchanged.
- R10: When `restore_en` is high in the same cycle as a class code or `int_entry`, the restore wins for all six flags.
- R11: `irq_masked` equals I, and `int_pass` is `nmi_req | (irq_req & ~I)`.
- R12: Class 9 clears I, 10 sets I, 11 clears D and 12 sets D. Each leaves the other flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_class | input | 4 | Instruction class code for flag update |
| alu_n | input | 1 | ALU negative result |
| alu_v | input | 1 | ALU overflow result (bit 6 for memory bit test) |
| alu_z | input | 1 | ALU zero result |
| alu_c | input | 1 | ALU carry result |
| restore_en | input | 1 | Load flags from a pulled stack byte |
| restore_byte | input | 8 | Byte pulled from the stack |
| int_entry | input | 1 | Interrupt or break entry in this cycle |
| int_is_brk | input | 1 | Entry was a software break |
| irq_req | input | 1 | Maskable interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| status | output | 8 | Current flags, bits 5 and 4 read 1 |
| push_byte | output | 8 | Byte for a stack push |
| irq_masked | output | 1 | Maskable requests are blocked |
| int_pass | output | 1 | A request is allowed through |

## Verification
A wrong stored flag shows on `status` at the first falling edge after the faulty update. It then corrupts `push_byte`, and for I also `int_pass`, in the same cycle, with nothing in between to hide it. A wrong update-enable shows only when the ALU values differ from the held flag, so the stimulus drives class codes with ALU inputs that disagree with the current state. Faults in the break marker and in the constant bit are combinational and show during the entry cycle itself.

// File: rtl/status_flags.sv
module status_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] op_class,
  input  logic       alu_n,
  input  logic       alu_v,
  input  logic       alu_z,
  input  logic       alu_c,
  input  logic       restore_en,
  input  logic [7:0] restore_byte,
  input  logic       int_entry,
  input  logic       int_is_brk,
  input  logic       irq_req,
  input  logic       nmi_req,
  output logic [7:0] status,
  output logic [7:0] push_byte,
  output logic       irq_masked,
  output logic       int_pass
);
  localparam logic [3:0] CL_NZ    = 4'd1;
  localparam logic [3:0] CL_ARITH = 4'd2;
  localparam logic [3:0] CL_SHCMP = 4'd3;
  localparam logic [3:0] CL_BITM  = 4'd4;
  localparam logic [3:0] CL_ZONLY = 4'd5;
  localparam logic [3:0] CL_CLC   = 4'd6;
  localparam logic [3:0] CL_SEC   = 4'd7;
  localparam logic [3:0] CL_CLV   = 4'd8;
  localparam logic [3:0] CL_CLI   = 4'd9;
  localparam logic [3:0] CL_SEI   = 4'd10;
  localparam logic [3:0] CL_CLD   = 4'd11;
  localparam logic [3:0] CL_SED   = 4'd12;

  logic f_n, f_v, f_d, f_i, f_z, f_c;
  logic n_nx, v_nx, d_nx, i_nx, z_nx, c_nx;
  logic we_n, we_z, we_v, we_c;

  assign we_n = (op_class == CL_NZ) || (op_class == CL_ARITH) ||
                (op_class == CL_SHCMP) || (op_class == CL_BITM);
  assign we_z = we_n || (op_class == CL_ZONLY);
  assign we_v = (op_class == CL_ARITH) || (op_class == CL_BITM);
  assign we_c = (op_class == CL_ARITH) || (op_class == CL_SHCMP);

  assign n_nx = we_n ? alu_n : f_n;
  assign z_nx = we_z ? alu_z : f_z;
  assign v_nx = we_v ? alu_v : (op_class == CL_CLV) ? 1'b0 : f_v;
  assign c_nx = we_c ? alu_c :
                (op_class == CL_CLC) ? 1'b0 :
                (op_class == CL_SEC) ? 1'b1 : f_c;

  always_comb begin
    d_nx = f_d;
    i_nx = f_i;
    if (op_class == CL_CLD) d_nx = 1'b0;
    if (op_class == CL_SED) d_nx = 1'b1;
    if (op_class == CL_CLI) i_nx = 1'b0;
    if (op_class == CL_SEI) i_nx = 1'b1;
    if (int_entry) begin
      d_nx = 1'b0;
      i_nx = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {f_n, f_v, f_d, f_i, f_z, f_c} <= 6'b000100;
    end else if (restore_en) begin
      {f_n, f_v} <= restore_byte[7:6];
      {f_d, f_i, f_z, f_c} <= restore_byte[3:0];
    end else begin
      {f_n, f_v, f_d, f_i, f_z, f_c} <= {n_nx, v_nx, d_nx, i_nx, z_nx, c_nx};
    end
  end

  assign status     = {f_n, f_v, 1'b1, 1'b1, f_d, f_i, f_z, f_c};
  assign push_byte  = {f_n, f_v, 1'b1, int_entry ? int_is_brk : 1'b1, f_d, f_i, f_z, f_c};
  assign irq_masked = f_i;
  assign int_pass   = nmi_req | (irq_req & ~f_i);
endmodule

module status_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] op_class,
  input logic       alu_z,
  input logic       restore_en,
  input logic [7:0] restore_byte,
  input logic       int_entry,
  input logic       irq_req,
  input logic       nmi_req,
  input logic [7:0] status,
  input logic       int_pass
);
  AST_RESTORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    restore_en |=> status == ($past(restore_byte) | 8'h30)); // R4
  AST_RESTORE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_en && int_entry && !restore_byte[2]) |=> !status[2]); // R10
  AST_ENTRY_DI: assert property (@(posedge clk) disable iff (!rst_n)
    (int_entry && !restore_en) |=> (!status[3] && status[2])); // R5
  AST_V_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore_en && op_class != 4'd2 && op_class != 4'd4 && op_class != 4'd8)
      |=> $stable(status[6])); // R6
  AST_C_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore_en && op_class != 4'd2 && op_class != 4'd3 && op_class != 4'd6 && op_class != 4'd7)
      |=> $stable(status[0])); // R7
  AST_ZONLY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore_en && op_class == 4'd5) |=> ($stable(status[7:6]) && status[1] == $past(alu_z))); // R9
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !nmi_req && status[2]) |-> !int_pass); // R11
endmodule

bind status_flags status_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_class(op_class), .alu_z(alu_z),
  .restore_en(restore_en), .restore_byte(restore_byte), .int_entry(int_entry),
  .irq_req(irq_req), .nmi_req(nmi_req), .status(status), .int_pass(int_pass)
);

// File: tb/tb_status_flags.sv
`timescale 1ns/1ps
module tb_status_flags;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] op_class;
  logic       alu_n, alu_v, alu_z, alu_c;
  logic       restore_en;
  logic [7:0] restore_byte;
  logic       int_entry, int_is_brk, irq_req, nmi_req;
  logic [7:0] status, push_byte;
  logic       irq_masked, int_pass;

  int checks = 0;
  int failures = 0;
  bit m_n, m_v, m_d, m_i, m_z, m_c;

  always #2.5 clk = ~clk;

  status_flags dut (
    .clk(clk), .rst_n(rst_n), .op_class(op_class),
    .alu_n(alu_n), .alu_v(alu_v), .alu_z(alu_z), .alu_c(alu_c),
    .restore_en(restore_en), .restore_byte(restore_byte),
    .int_entry(int_entry), .int_is_brk(int_is_brk),
    .irq_req(irq_req), .nmi_req(nmi_req),
    .status(status), .push_byte(push_byte),
    .irq_masked(irq_masked), .int_pass(int_pass)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_status();
    return {m_n, m_v, 2'b11, m_d, m_i, m_z, m_c};
  endfunction

  task automatic model_edge();
    if (restore_en) begin
      m_n = restore_byte[7]; m_v = restore_byte[6]; m_d = restore_byte[3];
      m_i = restore_byte[2]; m_z = restore_byte[1]; m_c = restore_byte[0];
      return;
    end
    case (op_class)
      4'd1:  begin m_n = alu_n; m_z = alu_z; end
      4'd2:  begin m_n = alu_n; m_z = alu_z; m_v = alu_v; m_c = alu_c; end
      4'd3:  begin m_n = alu_n; m_z = alu_z; m_c = alu_c; end
      4'd4:  begin m_n = alu_n; m_z = alu_z; m_v = alu_v; end
      4'd5:  m_z = alu_z;
      4'd6:  m_c = 1'b0;
      4'd7:  m_c = 1'b1;
      4'd8:  m_v = 1'b0;
      4'd9:  m_i = 1'b0;
      4'd10: m_i = 1'b1;
      4'd11: m_d = 1'b0;
      4'd12: m_d = 1'b1;
      default: ;
    endcase
    if (int_entry) begin m_d = 1'b0; m_i = 1'b1; end
  endtask

  task automatic step(input string tag, input logic [3:0] cls, input logic [3:0] nvzc,
                      input logic rs, input logic [7:0] rb, input logic en, input logic brk,
                      input logic irq, input logic nmi);
    logic [7:0] exp_push;
    op_class = cls; {alu_n, alu_v, alu_z, alu_c} = nvzc;
    restore_en = rs; restore_byte = rb; int_entry = en; int_is_brk = brk;
    irq_req = irq; nmi_req = nmi;
    #1;
    exp_push = m_status();
    if (en) exp_push[4] = brk;
    check(en ? "R3 push_byte" : "R2 push_byte", push_byte, exp_push);
    check("R11 irq_masked/int_pass", {6'd0, irq_masked, int_pass},
          {6'd0, m_i, nmi | (irq & ~m_i)});
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag, status, m_status());
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    op_class = 4'd0; {alu_n, alu_v, alu_z, alu_c} = 4'hF;
    restore_en = 1'b0; restore_byte = 8'hFF; int_entry = 1'b0; int_is_brk = 1'b0;
    irq_req = 1'b0; nmi_req = 1'b0;
    {m_n, m_v, m_d, m_i, m_z, m_c} = 6'b000100;
    repeat (3) @(negedge clk);
    check("R1 reset status", status, 8'h34);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", status, 8'h34);

    step("R7 set C",            4'd7,  4'b0000, 0, 8'h00, 0, 0, 0, 0);
    step("R6 arith writes V",   4'd2,  4'b1100, 0, 8'h00, 0, 0, 0, 0);
    step("R6 compare keeps V",  4'd3,  4'b0011, 0, 8'h00, 0, 0, 0, 0);
    step("R7 load keeps C",     4'd1,  4'b1000, 0, 8'h00, 0, 0, 0, 0);
    step("R9 Z only",           4'd5,  4'b0010, 0, 8'h00, 0, 0, 0, 0);
    step("R8 class 0 no effect",4'd0,  4'b0101, 0, 8'h00, 0, 0, 0, 0);
    step("R8 class 14 no effect",4'd14,4'b0101, 0, 8'h00, 0, 0, 0, 0);
    step("R12 set D",           4'd12, 4'b0000, 0, 8'h00, 0, 0, 0, 0);
    step("R12 clear I",         4'd9,  4'b0000, 0, 8'h00, 0, 0, 1, 0);
    step("R5 hw entry",         4'd0,  4'b0000, 0, 8'h00, 1, 0, 1, 0);
    step("R3 break entry",      4'd0,  4'b0000, 0, 8'h00, 1, 1, 1, 0);
    step("R10 restore wins",    4'd7,  4'b1111, 1, 8'h30, 1, 1, 0, 0);
    step("R4 restore ignores 5,4", 4'd0, 4'b0000, 1, 8'hCB, 0, 0, 1, 0);
    step("R6 clear V",          4'd8,  4'b1111, 0, 8'h00, 0, 0, 1, 0);
    step("R12 clear D",         4'd11, 4'b1111, 0, 8'h00, 0, 0, 0, 1);
    step("R12 set I",           4'd10, 4'b1111, 0, 8'h00, 0, 0, 1, 1);
    step("R7 clear C",          4'd6,  4'b1111, 0, 8'h00, 0, 0, 1, 0);
    step("R6 bit test V",       4'd4,  4'b0100, 0, 8'h00, 0, 0, 0, 0);

    for (int k = 0; k < 4000; k++) begin
      logic rs;
      rs = ($urandom % 8) == 0;
      step(rs ? "R10 random restore" : "R8 random update",
           4'($urandom), 4'($urandom), rs, 8'($urandom),
           ($urandom % 6) == 0, 1'($urandom), 1'($urandom), ($urandom % 4) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule